// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Sequencer

This block plans refresh for an asynchronous EDO DRAM from the controller clock. In normal operation a free-running interval timer raises a distributed CAS-before-RAS refresh request. The access arbiter answers the request with a grant when it starts the refresh cycle and with a done pulse when the cycle ends. Only a refresh that completes after a grant counts as a refresh of a row.

The host asks for self refresh by holding `sr_req` high. The sequencer first issues guard refreshes close to the entry. It then requests one more CBR start and tells the pad logic to keep RAS low by raising `ras_hold`. After the minimum hold time it reports `sr_active`. When the host drops the request, the sequencer releases RAS at once and issues guard refreshes again.

The guard rule depends on the refresh style. In the distributed style (`BURST_STYLE = 0`), one refresh is issued right before entry and one right after exit. In the burst style (`BURST_STYLE = 1`), a full sweep of `ROWS` refreshes is issued on each side. In both styles, self refresh cannot be entered again until `ROWS` refreshes have completed since the last exit. A request that arrives too early is not lost: it stays pending and is served once the sweep is done.

Top module: `refresh_sequencer`

## Requirements
- R1: After reset, `ref_req`, `ras_hold` and `sr_active` are low, and the row sweep counts as complete, so the first self-refresh request is accepted.
- R2: Outside self refresh, `ref_req` rises `TREF_NS/CLK_NS` clock cycles after reset is released, and again every `TREF_NS/CLK_NS` cycles after that.
- R3: `ref_req` stays high until `ref_grant` is seen with it, and is low in the cycle after that grant.
- R4: Self refresh is not entered again until `ROWS` refreshes (a `ref_done` after a grant) have completed since the last exit. A `sr_req` held during that time is served once the count is reached.
- R5: In the distributed style, exactly one refresh completes between an accepted request and the rise of `ras_hold`. `ref_req` is high in the cycle right after the exit.
- R6: In the burst style, `ROWS` refreshes complete before `ras_hold` rises. After an exit, `ref_req` is high at once, and another `ROWS` refreshes complete before the next entry's guards.
- R7: After the guards, a grant of the entry request raises `ras_hold` in the next cycle. `sr_active` rises `SR_HOLD_NS/CLK_NS + 1` cycles after `ras_hold`, and `sr_active` is never high without `ras_hold`.
- R8: `ras_hold` stays high even when `sr_req` falls early. With `sr_req` low, `ras_hold` and `sr_active` both fall one cycle after `sr_active` rises.
- R9: `ref_req` is never high while `ras_hold` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_req | input | 1 | Host level request to be in self refresh |
| ref_grant | input | 1 | Arbiter starts the requested CBR cycle |
| ref_done | input | 1 | Arbiter finished the granted refresh cycle |
| ref_req | output | 1 | Refresh (or self-refresh entry CBR) wanted |
| sr_active | output | 1 | Minimum RAS-low time met; DRAM is in self refresh |
| ras_hold | output | 1 | Keep RAS low after the entry CBR start |

## Verification
The embedded assertions check the following on every cycle:
- `sr_active` never appears without `ras_hold`.
- No refresh request overlaps a held RAS.
- `ras_hold` rises only on an entry grant.
- RAS is released only after self refresh was reached.
- The entry guard phase is never reached with an incomplete sweep.
- The counters never pass their limits.

Only the bench scenarios can show the timing and counts across cycles: the exact request spacing, the number of completed refreshes between a request and entry for each style, the hold-to-active delay, and that an early re-entry request is delayed until a full sweep and then served.

// File: rtl/rfs_pkg.sv
`timescale 1ns/1ps
package rfs_pkg;
  typedef enum logic [2:0] {
    RS_NORMAL      = 3'd0,
    RS_ENTRY_GUARD = 3'd1,
    RS_SELF        = 3'd2,
    RS_EXIT_GUARD  = 3'd3,
    RS_SWEEP       = 3'd4
  } rfs_state_e;
endpackage

// File: rtl/rfs_interval_timer.sv
`timescale 1ns/1ps
module rfs_interval_timer #(
  parameter int INTERVAL = 780
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= tick ? '0 : cnt + CW'(1);
    end
  end

  // R2: the phase counter never leaves its interval
  a_r2_phase_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(INTERVAL - 1));
endmodule

// File: rtl/rfs_sat_counter.sv
`timescale 1ns/1ps
module rfs_sat_counter #(
  parameter int MAX      = 4096,
  parameter bit RST_FULL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic full
);
  localparam int W = $clog2(MAX + 1);

  logic [W-1:0] cnt;

  assign full = (cnt == W'(MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= RST_FULL ? W'(MAX) : '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc && !full) begin
      cnt <= cnt + W'(1);
    end
  end

  // R4: counting stops at the limit and stays there until cleared
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= W'(MAX));
  a_r4_sticky_full: assert property (@(posedge clk) disable iff (rst)
    (full && !clr) |=> full);
endmodule

// File: rtl/refresh_sequencer.sv
`timescale 1ns/1ps
module refresh_sequencer
  import rfs_pkg::*;
#(
  parameter int CLK_NS      = 20,
  parameter int TREF_NS     = 15600,
  parameter int ROWS        = 4096,
  parameter int SR_HOLD_NS  = 100000,
  parameter bit BURST_STYLE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic sr_req,
  input  logic ref_grant,
  input  logic ref_done,
  output logic ref_req,
  output logic sr_active,
  output logic ras_hold
);
  localparam int INTERVAL_CYC = TREF_NS / CLK_NS;
  localparam int HOLD_CYC     = SR_HOLD_NS / CLK_NS;
  localparam int GUARD_N      = BURST_STYLE ? ROWS : 1;

  rfs_state_e state_q, state_d;
  logic pend_q, busy_q, hold_q, act_q;
  logic tick, kick, guard_clr, done_ev, entry_start, exit_go;
  logic sweep_full, guard_full, hold_full;
  logic moving;

  assign done_ev     = busy_q && ref_done;
  assign entry_start = (state_q == RS_SELF) && pend_q && ref_grant;
  assign exit_go     = (state_q == RS_SELF) && act_q && !sr_req;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RS_NORMAL:      if (sr_req && sweep_full) state_d = RS_ENTRY_GUARD;
      RS_ENTRY_GUARD: if (guard_full && !pend_q && !busy_q)
                        state_d = sr_req ? RS_SELF : RS_NORMAL;
      RS_SELF:        if (exit_go) state_d = RS_EXIT_GUARD;
      RS_EXIT_GUARD:  if (guard_full) state_d = RS_SWEEP;
      RS_SWEEP:       if (sweep_full) state_d = RS_NORMAL;
      default:        state_d = RS_NORMAL;
    endcase
  end

  assign moving    = (state_d != state_q);
  assign guard_clr = moving && (state_d == RS_ENTRY_GUARD || state_d == RS_EXIT_GUARD);
  assign kick      = guard_clr || (moving && state_d == RS_SELF);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RS_NORMAL;
      pend_q  <= 1'b0;
      busy_q  <= 1'b0;
      hold_q  <= 1'b0;
      act_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ref_grant && pend_q) pend_q <= 1'b0;
      if (tick || kick)        pend_q <= 1'b1;
      if (ref_grant && pend_q && state_q != RS_SELF) busy_q <= 1'b1;
      else if (ref_done)                             busy_q <= 1'b0;
      if (entry_start)  hold_q <= 1'b1;
      else if (exit_go) hold_q <= 1'b0;
      if (exit_go) act_q <= 1'b0;
      else if (state_q == RS_SELF && hold_q && hold_full) act_q <= 1'b1;
    end
  end

  rfs_interval_timer #(.INTERVAL(INTERVAL_CYC)) u_interval (
    .clk(clk), .rst(rst), .run(state_q != RS_SELF), .restart(kick), .tick(tick)
  );

  rfs_sat_counter #(.MAX(ROWS), .RST_FULL(1'b1)) u_sweep (
    .clk(clk), .rst(rst), .clr(exit_go), .inc(done_ev), .full(sweep_full)
  );

  rfs_sat_counter #(.MAX(GUARD_N), .RST_FULL(1'b0)) u_guard (
    .clk(clk), .rst(rst), .clr(guard_clr), .inc(done_ev), .full(guard_full)
  );

  rfs_sat_counter #(.MAX(HOLD_CYC), .RST_FULL(1'b0)) u_hold (
    .clk(clk), .rst(rst), .clr(!hold_q), .inc(hold_q), .full(hold_full)
  );

  assign ref_req   = pend_q;
  assign ras_hold  = hold_q;
  assign sr_active = act_q;

  // R7: self refresh is only reported with RAS held low
  a_r7_active_needs_hold: assert property (@(posedge clk) disable iff (rst)
    sr_active |-> ras_hold);
  // R7: RAS hold starts only from a granted entry request in the self state
  a_r7_hold_from_grant: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_hold) |-> ($past(ref_grant) && $past(state_q) == RS_SELF));
  // R8: RAS is released only after the minimum hold was reached
  a_r8_release_after_active: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_hold) |-> $past(sr_active));
  // R9: no refresh request while RAS is held
  a_r9_quiet_while_held: assert property (@(posedge clk) disable iff (rst)
    ras_hold |-> !ref_req);
  // R4: entry guards only run with a complete sweep behind them
  a_r4_guard_needs_sweep: assert property (@(posedge clk) disable iff (rst)
    (state_q == RS_ENTRY_GUARD) |-> sweep_full);
endmodule

// File: tb/refresh_sequencer_tb.sv
`timescale 1ns/1ps
module refresh_sequencer_arb (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic req,
  input  logic hold,
  output logic gnt,
  output logic done,
  output int   cnt
);
  initial begin
    gnt  = 1'b0;
    done = 1'b0;
    cnt  = 0;
    forever begin
      @(negedge clk);
      if (en && req && !rst) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        gnt = 1'b1;
        @(negedge clk);
        gnt = 1'b0;
        repeat ($urandom_range(1, 3)) @(negedge clk);
        if (!hold) begin
          done = 1'b1;
          cnt  = cnt + 1;
          @(negedge clk);
          done = 1'b0;
        end
      end
    end
  end
endmodule

module refresh_sequencer_tb;
  localparam int CLK_NS     = 20;
  localparam int TREF_NS    = 400;
  localparam int ROWS       = 8;
  localparam int SR_HOLD_NS = 600;
  localparam int INTERVAL   = TREF_NS / CLK_NS;
  localparam int HOLD       = SR_HOLD_NS / CLK_NS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic sr_a = 1'b0, en_a = 1'b0, gnt_a, done_a, req_a, hold_a, act_a;
  logic sr_b = 1'b0, en_b = 1'b0, gnt_b, done_b, req_b, hold_b, act_b;
  int cnt_a, cnt_b;
  int checks = 0, fails = 0;
  int viol_r9 = 0, viol_r7 = 0;
  bit finished = 1'b0;

  refresh_sequencer #(.CLK_NS(CLK_NS), .TREF_NS(TREF_NS), .ROWS(ROWS),
                      .SR_HOLD_NS(SR_HOLD_NS), .BURST_STYLE(1'b0)) u_dut (
    .clk(clk), .rst(rst), .sr_req(sr_a), .ref_grant(gnt_a), .ref_done(done_a),
    .ref_req(req_a), .sr_active(act_a), .ras_hold(hold_a));

  refresh_sequencer #(.CLK_NS(CLK_NS), .TREF_NS(TREF_NS), .ROWS(ROWS),
                      .SR_HOLD_NS(SR_HOLD_NS), .BURST_STYLE(1'b1)) u_dut_burst (
    .clk(clk), .rst(rst), .sr_req(sr_b), .ref_grant(gnt_b), .ref_done(done_b),
    .ref_req(req_b), .sr_active(act_b), .ras_hold(hold_b));

  refresh_sequencer_arb u_arb_a (.clk(clk), .rst(rst), .en(en_a), .req(req_a),
    .hold(hold_a), .gnt(gnt_a), .done(done_a), .cnt(cnt_a));
  refresh_sequencer_arb u_arb_b (.clk(clk), .rst(rst), .en(en_b), .req(req_b),
    .hold(hold_b), .gnt(gnt_b), .done(done_b), .cnt(cnt_b));

  function automatic int exp_guards(input bit burst);
    return burst ? ROWS : 1;
  endfunction

  function automatic int exp_act_delay();
    return HOLD + 1;
  endfunction

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic check_range(input string tag, input int actual, input int lo, input int hi);
    checks++;
    if (actual < lo || actual > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, actual, lo, hi);
    end
  endtask

  always @(negedge clk) begin
    #3;
    if (!rst) begin
      if ((hold_a && req_a) || (hold_b && req_b)) viol_r9++;
      if ((act_a && !hold_a) || (act_b && !hold_b)) viol_r7++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int n0;
    void'($urandom(32'd4242));
    repeat (3) step();
    // R1: reset state
    check("R1 ref_req after reset", int'(req_a), 0);
    check("R1 ras_hold after reset", int'(hold_a), 0);
    check("R1 sr_active after reset", int'(act_a | act_b), 0);

    rst = 1'b0;
    n = 0;
    do begin step(); n++; end while (!req_a && n < 200);
    check("R2 first request delay", n, INTERVAL);
    check("R2 burst instance first request", int'(req_b), 1);

    repeat (30) step();
    check("R3 request held without grant", int'(req_a), 1);

    en_a = 1'b1;
    en_b = 1'b1;
    do step(); while (!gnt_a);
    step();
    check("R3 request clears after grant", int'(req_a), 0);

    while (req_a) step();
    while (!req_a) step();
    for (int k = 0; k < 3; k++) begin
      n = 0;
      while (req_a) begin step(); n++; end
      while (!req_a) begin step(); n++; end
      check("R2 request spacing", n, INTERVAL);
    end

    // R5 and R7: distributed-style entry
    en_a = 1'b0;
    repeat (12) step();
    while (!req_a) step();
    sr_a = 1'b1;
    en_a = 1'b1;
    n0 = cnt_a;
    while (!hold_a) step();
    check("R5 guard refreshes before entry", cnt_a - n0, exp_guards(1'b0));
    n = 0;
    while (!act_a) begin
      step();
      n++;
      if (n == 10) sr_a = 1'b0;
      if (n == 20) check("R8 hold kept after early release", int'(hold_a), 1);
    end
    check("R7 hold to active delay", n, exp_act_delay());
    step();
    check("R8 hold released after active", int'(hold_a), 0);
    check("R8 active cleared on exit", int'(act_a), 0);
    check("R5 guard request right after exit", int'(req_a), 1);

    // R4: early re-entry waits for a full sweep
    sr_a = 1'b1;
    n0 = cnt_a;
    while (!hold_a) step();
    check_range("R4 refreshes before re-entry", cnt_a - n0, ROWS + 1, ROWS + 2);
    sr_a = 1'b0;
    while (!act_a) step();
    step();
    check("R8 second exit", int'(hold_a), 0);

    // R6: burst-style guards
    en_b = 1'b0;
    repeat (12) step();
    while (!req_b) step();
    sr_b = 1'b1;
    en_b = 1'b1;
    n0 = cnt_b;
    while (!hold_b) step();
    check("R6 burst guards before entry", cnt_b - n0, exp_guards(1'b1));
    n = 0;
    while (!act_b) begin
      step();
      n++;
      if (n == 5) sr_b = 1'b0;
    end
    check("R7 burst hold to active delay", n, exp_act_delay());
    step();
    check("R6 burst guard request after exit", int'(req_b), 1);
    sr_b = 1'b1;
    n0 = cnt_b;
    while (!hold_b) step();
    check_range("R6 burst refreshes before re-entry", cnt_b - n0, 2 * ROWS, 2 * ROWS + 1);
    sr_b = 1'b0;
    while (!act_b) step();
    step();
    check("R8 burst exit", int'(hold_b), 0);

    // random host requests on the distributed instance
    for (int k = 0; k < 24; k++) begin
      sr_a = 1'($urandom_range(0, 1));
      repeat ($urandom_range(5, 90)) step();
    end
    sr_a = 1'b0;
    repeat (60) step();
    while (hold_a) step();
    check("R9 no request while RAS held", viol_r9, 0);
    check("R7 active only with hold", viol_r7, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule